// File: doc/BRIEF.md
# Instrument Status Summary Byte with Service Request

This block builds the 8-bit status summary byte of a bus-attached instrument and raises a service-request line toward the bus controller. Several sources feed the byte. Error-queue and output-queue occupancy flags are taken directly. An extended-event summary level is also taken directly. A sticky standard event register, gated by its own enable mask, supplies one more bit. A master summary bit is formed from the byte and a writable service request enable mask.

The byte can be read in two forms, and they differ only in bit 6. The status-query form carries the level-derived master summary in bit 6 and has no side effects. The serial-poll form carries an edge-set request flag in bit 6, and the poll strobe clears that flag. A clear-status strobe empties the standard event register. When the strobe is qualified as arriving right after a message terminator, the block also pulses a flush request to the external output queue. Both read forms are combinational from the current register state and the input flags.

Top module: `stsb_top`

## Requirements
- R1: Bits 0, 1 and 7 read as 0 in both read forms at all times.
- R2: Status bit 2 equals `errQNotEmpty`, bit 3 equals `extSummary` and bit 4 equals `outQNotEmpty`, in the same cycle.
- R3: A 1 on any `stdEvtPulse` bit sets the matching bit of the standard event register, and the bit stays set until cleared. From the cycle after that edge, bit 5 reads as the OR of (event register AND standard enable mask). The enable mask is loaded from `stdEnData` when `stdEnWe` is high.
- R4: Bit 6 of `stbQuery` is 1 exactly when the status bits other than bit 6, ANDed with the service request enable mask, have any bit set. Reading this form changes no state.
- R5: The request flag is set at the clock edge that follows a 0-to-1 change of the master summary. `srq` and bit 6 of `stbPoll` both show the flag.
- R6: The request flag is cleared at the edge where the master summary is 0. It is also cleared at the edge where `spollRd` is high, unless the master summary rises in that same cycle, in which case the flag is set.
- R7: `clrStatus` empties the standard event register at the next edge, so bit 5 falls. Event pulses that arrive in the same cycle are still captured. A plain clear leaves bit 4 following `outQNotEmpty`.
- R8: `outQFlush` is 1 exactly when `clrStatus` and `clrAfterTerm` are both high.
- R9: The service request enable mask is loaded from `sreData` when `sreWe` is high. Bit 6 of the written value is dropped: it reads back as 0 on `sreReadback` and never feeds the master summary. A 0 in any other mask bit keeps the matching status bit out of the master summary and `srq`.
- R10: While `rstN` is low, the event register, both enable masks and the request flag are zeroed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stdEvtPulse | input | 8 | Standard event pulses, sticky once captured |
| stdEnWe | input | 1 | Load standard event enable mask |
| stdEnData | input | 8 | New standard event enable mask |
| extSummary | input | 1 | Extended-event summary level |
| errQNotEmpty | input | 1 | Error queue holds an entry |
| outQNotEmpty | input | 1 | Output queue holds an entry |
| sreWe | input | 1 | Load service request enable mask |
| sreData | input | 8 | New service request enable mask |
| spollRd | input | 1 | Serial-poll read strobe |
| clrStatus | input | 1 | Clear-status strobe |
| clrAfterTerm | input | 1 | Clear-status arrived right after a terminator |
| stbQuery | output | 8 | Status byte, master summary in bit 6 |
| stbPoll | output | 8 | Status byte, request flag in bit 6 |
| sreReadback | output | 8 | Service request enable mask readback |
| srq | output | 1 | Service request line |
| outQFlush | output | 1 | Flush request to the output queue |

## Verification
Several properties hold on every cycle and are checked there. The unused bits stay zero. The two read forms agree outside bit 6. Masked-off status bits never raise the master summary. Bit 6 of the mask readback stays zero. A rising master summary raises `srq` on the following cycle. A low summary or a serial poll drops it on the following cycle. Other behaviour depends on stimulus order and is shown only by the bench scenarios: sticky capture of events, clear-status racing an incoming pulse, and a poll that coincides with a summary rise. The flush qualifier and the many mask-and-flag combinations are also exercised only through the bench's vectors.

// File: rtl/stsb_pkg.sv
package stsb_pkg;
  localparam int SB_W    = 8;
  localparam int EAV_BIT = 2;
  localparam int EES_BIT = 3;
  localparam int MAV_BIT = 4;
  localparam int ESB_BIT = 5;
  localparam int SUM_BIT = 6;

  typedef struct packed {
    logic loadStdEn;
    logic loadSre;
    logic clrStdEvt;
    logic flushOutQ;
    logic pollDone;
  } stsbCtl_t;
endpackage

// File: rtl/stsb_ctrl.sv
module stsb_ctrl
  import stsb_pkg::*;
(
  input  logic     stdEnWe,
  input  logic     sreWe,
  input  logic     spollRd,
  input  logic     clrStatus,
  input  logic     clrAfterTerm,
  output stsbCtl_t ctl
);
  always_comb begin
    ctl           = '0;
    ctl.loadStdEn = stdEnWe;
    ctl.loadSre   = sreWe;
    ctl.clrStdEvt = clrStatus;
    ctl.flushOutQ = clrStatus & clrAfterTerm;
    ctl.pollDone  = spollRd;
  end
endmodule

// File: rtl/stsb_datapath.sv
module stsb_datapath
  import stsb_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  stsbCtl_t         ctl,
  input  logic [EVT_W-1:0] stdEvtPulse,
  input  logic [EVT_W-1:0] stdEnData,
  input  logic [SB_W-1:0]  sreData,
  input  logic             errQNotEmpty,
  input  logic             outQNotEmpty,
  input  logic             extSummary,
  output logic [SB_W-1:0]  stbQuery,
  output logic [SB_W-1:0]  stbPoll,
  output logic [SB_W-1:0]  sreReadback,
  output logic             rqs,
  output logic             mssPrev
);
  localparam logic [SB_W-1:0] SUM_MASK = ~(SB_W'(1) << SUM_BIT);

  logic [EVT_W-1:0] stdEvt;
  logic [EVT_W-1:0] stdEn;
  logic [SB_W-1:0]  sre;
  logic [SB_W-1:0]  sbBase;
  logic             esb;
  logic             mss;
  logic             mssRise;
  logic             rqsNext;

  // sticky standard events; a pulse coinciding with a clear survives
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stdEvt <= '0;
      stdEn  <= '0;
      sre    <= '0;
    end else begin
      stdEvt <= (ctl.clrStdEvt ? '0 : stdEvt) | stdEvtPulse;
      if (ctl.loadStdEn) stdEn <= stdEnData;
      if (ctl.loadSre)   sre   <= sreData & SUM_MASK;
    end
  end

  assign esb = |(stdEvt & stdEn);

  always_comb begin
    sbBase          = '0;
    sbBase[EAV_BIT] = errQNotEmpty;
    sbBase[EES_BIT] = extSummary;
    sbBase[MAV_BIT] = outQNotEmpty;
    sbBase[ESB_BIT] = esb;
  end

  assign mss     = |(sbBase & sre & SUM_MASK);
  assign mssRise = mss & ~mssPrev;

  always_comb begin
    if (mssRise)           rqsNext = 1'b1;
    else if (!mss)         rqsNext = 1'b0;
    else if (ctl.pollDone) rqsNext = 1'b0;
    else                   rqsNext = rqs;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rqs     <= 1'b0;
      mssPrev <= 1'b0;
    end else begin
      rqs     <= rqsNext;
      mssPrev <= mss;
    end
  end

  always_comb begin
    stbQuery          = sbBase;
    stbQuery[SUM_BIT] = mss;
    stbPoll           = sbBase;
    stbPoll[SUM_BIT]  = rqs;
  end

  assign sreReadback = sre;
endmodule

// File: rtl/stsb_top.sv
module stsb_top
  import stsb_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [EVT_W-1:0] stdEvtPulse,
  input  logic             stdEnWe,
  input  logic [EVT_W-1:0] stdEnData,
  input  logic             extSummary,
  input  logic             errQNotEmpty,
  input  logic             outQNotEmpty,
  input  logic             sreWe,
  input  logic [7:0]       sreData,
  input  logic             spollRd,
  input  logic             clrStatus,
  input  logic             clrAfterTerm,
  output logic [7:0]       stbQuery,
  output logic [7:0]       stbPoll,
  output logic [7:0]       sreReadback,
  output logic             srq,
  output logic             outQFlush
);
  stsbCtl_t ctl;
  logic     rqs;
  logic     mssPrev;

  stsb_ctrl u_ctrl (
    .stdEnWe(stdEnWe), .sreWe(sreWe), .spollRd(spollRd),
    .clrStatus(clrStatus), .clrAfterTerm(clrAfterTerm), .ctl(ctl)
  );

  stsb_datapath #(.EVT_W(EVT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .stdEvtPulse(stdEvtPulse), .stdEnData(stdEnData), .sreData(sreData),
    .errQNotEmpty(errQNotEmpty), .outQNotEmpty(outQNotEmpty),
    .extSummary(extSummary),
    .stbQuery(stbQuery), .stbPoll(stbPoll), .sreReadback(sreReadback),
    .rqs(rqs), .mssPrev(mssPrev)
  );

  assign srq       = rqs;
  assign outQFlush = ctl.flushOutQ;
endmodule

// File: rtl/stsb_chk.sv
module stsb_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] stbQuery,
  input logic [7:0] stbPoll,
  input logic [7:0] sreReadback,
  input logic       srq,
  input logic       spollRd,
  input logic       mssPrev
);
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stbQuery[7] == 1'b0 && stbQuery[1:0] == 2'b00 &&
     stbPoll[7] == 1'b0 && stbPoll[1:0] == 2'b00));

  a_r5_forms_agree: assert property (@(posedge clk) disable iff (!rstN)
    ((stbQuery & 8'hBF) == (stbPoll & 8'hBF)));

  a_r5_rise_sets_srq: assert property (@(posedge clk) disable iff (!rstN)
    (stbQuery[6] && !mssPrev) |=> srq);

  a_r6_low_clears: assert property (@(posedge clk) disable iff (!rstN)
    !stbQuery[6] |=> !srq);

  a_r6_poll_clears: assert property (@(posedge clk) disable iff (!rstN)
    (spollRd && !(stbQuery[6] && !mssPrev)) |=> !srq);

  a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    ((stbQuery & sreReadback & 8'hBF) == 8'h00) |-> !stbQuery[6]);

  a_r9_bit6_readback: assert property (@(posedge clk) disable iff (!rstN)
    sreReadback[6] == 1'b0);
endmodule

bind stsb_top stsb_chk u_chk (
  .clk(clk), .rstN(rstN), .stbQuery(stbQuery), .stbPoll(stbPoll),
  .sreReadback(sreReadback), .srq(srq), .spollRd(spollRd),
  .mssPrev(u_dp.mssPrev)
);

// File: tb/sim_stsb_top.sv
module sim_stsb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] stdEvtPulse = '0;
  logic       stdEnWe = 1'b0;
  logic [7:0] stdEnData = '0;
  logic       extSummary = 1'b0;
  logic       errQNotEmpty = 1'b0;
  logic       outQNotEmpty = 1'b0;
  logic       sreWe = 1'b0;
  logic [7:0] sreData = '0;
  logic       spollRd = 1'b0;
  logic       clrStatus = 1'b0;
  logic       clrAfterTerm = 1'b0;
  logic [7:0] stbQuery, stbPoll, sreReadback;
  logic       srq, outQFlush;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  stsb_top u0 (.*);

  // {errQ, outQ, ext, sre[7:0], expected query byte}
  localparam logic [18:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b0, 8'h00, 8'h04},
    {1'b1, 1'b0, 1'b0, 8'h04, 8'h44},
    {1'b0, 1'b1, 1'b1, 8'h04, 8'h18},
    {1'b0, 1'b1, 1'b1, 8'h10, 8'h58},
    {1'b0, 1'b0, 1'b1, 8'h08, 8'h48},
    {1'b0, 1'b0, 1'b0, 8'hFF, 8'h00},
    {1'b1, 1'b1, 1'b1, 8'hE3, 8'h1C},
    {1'b1, 1'b0, 1'b0, 8'h40, 8'h04}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one clock edge, then settle
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    step(); step();
    // R10: reset state
    chk("R10 query", stbQuery, 8'h00);
    chk("R10 poll", stbPoll, 8'h00);
    chk("R10 sre", sreReadback, 8'h00);
    chk("R10 srq", {7'b0, srq}, 8'h00);
    rstN = 1'b1;
    step();
    // R10: std enable mask is zero after reset, so an event gives no ESB
    stdEvtPulse = 8'h01; step(); stdEvtPulse = '0;
    chk("R10 stdEn zero", stbQuery, 8'h00);
    clrStatus = 1'b1; step(); clrStatus = 1'b0;

    // vector walk: R2, R4, R9
    for (int i = 0; i < 8; i++) begin
      errQNotEmpty = VEC[i][18];
      outQNotEmpty = VEC[i][17];
      extSummary   = VEC[i][16];
      sreData      = VEC[i][15:8];
      sreWe = 1'b1; step(); sreWe = 1'b0;
      chk("R2/R4 query", stbQuery, VEC[i][7:0]);
      chk("R9 readback", sreReadback, VEC[i][15:8] & 8'hBF);
      chk("R1 poll low bits", stbPoll & 8'hBF, VEC[i][7:0] & 8'hBF);
    end
    errQNotEmpty = 1'b0; outQNotEmpty = 1'b0; extSummary = 1'b0;
    step(); step();

    // R3/R5: std event path into SRQ
    stdEnData = 8'h01; stdEnWe = 1'b1;
    sreData = 8'h20; sreWe = 1'b1;
    step(); stdEnWe = 1'b0; sreWe = 1'b0;
    step();
    chk("R5 idle srq", {7'b0, srq}, 8'h00);
    stdEvtPulse = 8'h01; step(); stdEvtPulse = '0;
    chk("R3 esb set", stbQuery, 8'h60);
    chk("R5 srq not yet", {7'b0, srq}, 8'h00);
    step();
    chk("R3 sticky", stbQuery, 8'h60);
    chk("R5 srq set", {7'b0, srq}, 8'h01);
    chk("R5 poll byte", stbPoll, 8'h60);
    step();
    chk("R4 query no clear", stbQuery, 8'h60);
    chk("R4 srq kept", {7'b0, srq}, 8'h01);

    // R6: poll clears RQS only
    spollRd = 1'b1; step(); spollRd = 1'b0;
    chk("R6 poll clears", stbPoll, 8'h20);
    chk("R6 srq low", {7'b0, srq}, 8'h00);
    chk("R6 mss kept", stbQuery, 8'h60);
    step();
    chk("R6 no reset", {7'b0, srq}, 8'h00);

    // R7/R8: plain clear keeps MAV, empties events
    outQNotEmpty = 1'b1; clrStatus = 1'b1; #1;
    chk("R8 no flush", {7'b0, outQFlush}, 8'h00);
    step(); clrStatus = 1'b0;
    chk("R7 esb cleared", stbQuery, 8'h10);
    outQNotEmpty = 1'b0;
    clrStatus = 1'b1; clrAfterTerm = 1'b1; #1;
    chk("R8 flush", {7'b0, outQFlush}, 8'h01);
    step(); clrStatus = 1'b0; clrAfterTerm = 1'b0; #1;
    chk("R8 flush drop", {7'b0, outQFlush}, 8'h00);

    // R6: MSS falling clears RQS
    stdEvtPulse = 8'h01; step(); stdEvtPulse = '0;
    step();
    chk("R6 rqs up", {7'b0, srq}, 8'h01);
    clrStatus = 1'b1; step(); clrStatus = 1'b0;
    chk("R6 mss low", stbQuery, 8'h00);
    step();
    chk("R6 mss fall clears", {7'b0, srq}, 8'h00);

    // R6: poll in the same cycle as MSS rise leaves RQS set
    stdEvtPulse = 8'h01; step(); stdEvtPulse = '0;
    spollRd = 1'b1; step(); spollRd = 1'b0;
    chk("R6 poll+rise", {7'b0, srq}, 8'h01);

    // R7: pulse coinciding with clear is kept
    stdEvtPulse = 8'h01; clrStatus = 1'b1; step();
    stdEvtPulse = '0; clrStatus = 1'b0;
    chk("R7 pulse kept", stbQuery & 8'h20, 8'h20);

    // R9: enable bit 6 does not create a summary
    sreData = 8'h40; sreWe = 1'b1; step(); sreWe = 1'b0;
    chk("R9 bit6 ignored", stbQuery, 8'h20);
    step();
    chk("R9 srq masked", {7'b0, srq}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule